// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Sequencer

This block lets a clocked host read and write an asynchronous static RAM of 65,536 words by 4 bits. The host raises a one-cycle request with a write flag, a 16-bit address and, for writes, a 4-bit data word. The block then runs a complete memory cycle on the RAM pins and answers with a one-cycle ready pulse. For reads, the ready pulse carries the captured data word.

On the memory side the block drives active-low chip-select, write-strobe and output-gate lines and the address. It drives the shared 4-bit data bus through a separate output, enable and input. Writes are timed by the write strobe: chip-select goes low together with it, and the output gate stays high for the whole write. Reads hold the output gate low for a programmable number of cycles and sample the bus on the last of them. After every read, the bus is kept idle for a programmable number of cycles before the block may drive it again.

All timing minimums are integer cycle counts. Each is the nanosecond figure divided by the clock period, rounded up, and each count is at least 1.

Top module: `sram_seq_ctrl`

## Requirements
- R1: After reset and whenever no operation is in progress, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_dq_oe` is 0 and `host_rdy` is 0.
- R2: A request with `host_we`=0 accepted at clock edge E holds `mem_ce_n`=0, `mem_oe_n`=0 and `mem_we_n`=1 for RD_WAIT_CYC cycles with `mem_addr` equal to the request address. It samples `mem_dq_i` at the end of the last of those cycles and presents that value on `host_rdata` with `host_rdy` in the next cycle, RD_WAIT_CYC cycles after E.
- R3: A request with `host_we`=1 accepted at edge E holds `mem_we_n`=0 and `mem_ce_n`=0 for exactly max(WR_PULSE_CYC, WR_SETUP_CYC) cycles. During those cycles `mem_dq_oe`=1 and `mem_dq_o` carries the request data. `host_rdy` follows in the cycle after the strobe rises, and the addressed word then holds the written data.
- R4: While `mem_ce_n` is 0, `mem_addr` does not change.
- R5: `mem_we_n` is 0 only while `mem_ce_n` is 0, and `mem_oe_n` is 1 during every write.
- R6: `mem_dq_oe` is never 1 while `mem_oe_n` is 0. At least TURN_CYC cycles with `mem_oe_n`=1 and `mem_dq_oe`=0 separate a read from a following write data phase.
- R7: `host_rdy` is high for exactly one cycle per accepted operation.
- R8: A request raised while an operation is in progress is ignored. It produces no memory cycle and no ready pulse, and it leaves the addressed word unchanged.
- R9: In the cycle after the write strobe rises, `mem_dq_oe` stays 1 with the same data (zero-hold release), and the bus is released before the next operation starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_req | input | 1 | One-cycle operation request, taken only when idle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 16 | Word address |
| host_wdata | input | 4 | Write data |
| host_rdy | output | 1 | One-cycle completion pulse |
| host_rdata | output | 4 | Read data, valid with `host_rdy` after a read |
| mem_ce_n | output | 1 | Memory chip-select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output gate, active low |
| mem_addr | output | 16 | Memory address |
| mem_dq_o | output | 4 | Data toward the memory |
| mem_dq_oe | output | 1 | Enable of the data drivers |
| mem_dq_i | input | 4 | Data from the memory bus |

## Verification
The checker watches the pin-level rules on every cycle. These are: no drive while the output gate is low, the write strobe only inside chip-select, a stable address during chip-select, a minimum strobe width and a minimum turnaround gap, and single-cycle ready pulses. Only the bench scenarios can show that a word written at one address comes back from a later read, that reads sample at the end of the access window rather than earlier, and that the exact latencies hold. The same goes for the exact strobe width and for the rule that a request arriving mid-operation leaves memory untouched.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RD   = 3'd1,
    ST_TURN = 3'd2,
    ST_WR   = 3'd3,
    ST_WEND = 3'd4
  } seq_state_t;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_seq_timer.sv
module sram_seq_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign zero   = (cnt_q == '0);
  assign cnt_en = load | ~zero;

  always_comb begin
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_seq_pkg::*;
#(
  parameter int RD_WAIT_CYC = 1,
  parameter int WE_LOW_CYC  = 1,
  parameter int TURN_CYC    = 1,
  parameter int CNT_W       = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             req_we,
  input  logic             tmr_zero,
  output logic             accept,
  output logic             capture,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             ce_n,
  output logic             we_n,
  output logic             oe_n,
  output logic             dq_oe,
  output logic             rdy
);

  localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_WAIT_CYC - 1);
  localparam logic [CNT_W-1:0] WR_LOAD = CNT_W'(WE_LOW_CYC - 1);
  localparam logic [CNT_W-1:0] TN_LOAD = CNT_W'(TURN_CYC - 1);

  seq_state_t st_q, st_d;
  logic       rdy_d;
  logic       ce_n_d, we_n_d, oe_n_d, dq_oe_d;

  // next-state process
  always_comb begin
    st_d     = st_q;
    accept   = 1'b0;
    capture  = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    rdy_d    = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req) begin
          accept   = 1'b1;
          tmr_load = 1'b1;
          if (req_we) begin
            st_d    = ST_WR;
            tmr_val = WR_LOAD;
          end else begin
            st_d    = ST_RD;
            tmr_val = RD_LOAD;
          end
        end
      end
      ST_RD: begin
        if (tmr_zero) begin
          capture  = 1'b1;
          rdy_d    = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = TN_LOAD;
          st_d     = ST_TURN;
        end
      end
      ST_TURN: begin
        if (tmr_zero) st_d = ST_IDLE;
      end
      ST_WR: begin
        if (tmr_zero) begin
          rdy_d = 1'b1;
          st_d  = ST_WEND;
        end
      end
      ST_WEND: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // strobes follow the state being entered, so they leave a register
  always_comb begin
    ce_n_d  = ~((st_d == ST_RD) | (st_d == ST_WR));
    oe_n_d  = ~(st_d == ST_RD);
    we_n_d  = ~(st_d == ST_WR);
    dq_oe_d = (st_d == ST_WR) | (st_d == ST_WEND);
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      ce_n  <= 1'b1;
      we_n  <= 1'b1;
      oe_n  <= 1'b1;
      dq_oe <= 1'b0;
      rdy   <= 1'b0;
    end else begin
      st_q  <= st_d;
      ce_n  <= ce_n_d;
      we_n  <= we_n_d;
      oe_n  <= oe_n_d;
      dq_oe <= dq_oe_d;
      rdy   <= rdy_d;
    end
  end

endmodule

// File: rtl/sram_seq_datapath.sv
module sram_seq_datapath #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic [DATA_W-1:0] dq_out,
  output logic [DATA_W-1:0] rdata
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (capture) rdata_q <= dq_in;
  end

  assign addr_out = addr_q;
  assign dq_out   = wdata_q;
  assign rdata    = rdata_q;

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 4,
  parameter int RD_WAIT_CYC  = 1,
  parameter int WR_PULSE_CYC = 1,
  parameter int WR_SETUP_CYC = 1,
  parameter int TURN_CYC     = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_rdy,
  output logic [DATA_W-1:0] host_rdata,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int WE_LOW_CYC = max2(WR_PULSE_CYC, WR_SETUP_CYC);
  localparam int MAX_CYC    = max2(max2(RD_WAIT_CYC, WE_LOW_CYC), TURN_CYC);
  localparam int CNT_W      = $clog2(MAX_CYC + 1);

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             accept, capture, tmr_load, tmr_zero;
  logic [CNT_W-1:0] tmr_val;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  sram_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  sram_seq_fsm #(
    .RD_WAIT_CYC (RD_WAIT_CYC),
    .WE_LOW_CYC  (WE_LOW_CYC),
    .TURN_CYC    (TURN_CYC),
    .CNT_W       (CNT_W)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .req      (host_req),
    .req_we   (host_we),
    .tmr_zero (tmr_zero),
    .accept   (accept),
    .capture  (capture),
    .tmr_load (tmr_load),
    .tmr_val  (tmr_val),
    .ce_n     (mem_ce_n),
    .we_n     (mem_we_n),
    .oe_n     (mem_oe_n),
    .dq_oe    (mem_dq_oe),
    .rdy      (host_rdy)
  );

  sram_seq_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .accept    (accept),
    .capture   (capture),
    .req_addr  (host_addr),
    .req_wdata (host_wdata),
    .dq_in     (mem_dq_i),
    .addr_out  (mem_addr),
    .dq_out    (mem_dq_o),
    .rdata     (host_rdata)
  );

endmodule

// File: rtl/sram_seq_ctrl_chk.sv
module sram_seq_ctrl_chk #(
  parameter int ADDR_W       = 16,
  parameter int WR_PULSE_CYC = 1,
  parameter int WR_SETUP_CYC = 1,
  parameter int TURN_CYC     = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_rdy,
  input logic              mem_ce_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_dq_oe,
  input logic [ADDR_W-1:0] mem_addr
);

  localparam int WE_LOW = (WR_PULSE_CYC > WR_SETUP_CYC) ? WR_PULSE_CYC : WR_SETUP_CYC;
  localparam int GW     = $clog2(TURN_CYC + 1) + 1;
  localparam int WW     = $clog2(WE_LOW + 1) + 1;

  logic [GW-1:0] gap_q;
  logic [WW-1:0] wlow_q;

  // cycles since the output gate was last low (saturating)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    gap_q <= GW'(TURN_CYC);
    else if (!mem_oe_n)            gap_q <= '0;
    else if (gap_q < GW'(TURN_CYC)) gap_q <= gap_q + 1'b1;
  end

  // length of the current write strobe (saturating)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    wlow_q <= '0;
    else if (mem_we_n)             wlow_q <= '0;
    else if (wlow_q < WW'(WE_LOW)) wlow_q <= wlow_q + 1'b1;
  end

  a_r6_no_drive_under_oe: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dq_oe && !mem_oe_n));

  a_r6_turnaround_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (gap_q >= GW'(TURN_CYC)));

  a_r5_we_inside_ce: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n));

  a_r3_data_during_we: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_dq_oe);

  a_r3_we_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (wlow_q >= WW'(WE_LOW)));

  a_r4_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

  a_r9_hold_after_we: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> mem_dq_oe);

  a_r7_rdy_single: assert property (@(posedge clk) disable iff (!rst_n)
    host_rdy |=> !host_rdy);

endmodule

bind sram_seq_ctrl sram_seq_ctrl_chk #(
  .ADDR_W       (ADDR_W),
  .WR_PULSE_CYC (WR_PULSE_CYC),
  .WR_SETUP_CYC (WR_SETUP_CYC),
  .TURN_CYC     (TURN_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .host_rdy  (host_rdy),
  .mem_ce_n  (mem_ce_n),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n),
  .mem_dq_oe (mem_dq_oe),
  .mem_addr  (mem_addr)
);

// File: tb/sram_seq_ctrl_test.sv
module sram_seq_ctrl_test;

  localparam int RDW = 2;
  localparam int WRP = 2;
  localparam int WRS = 3;
  localparam int TRN = 2;
  localparam int WLO = (WRP > WRS) ? WRP : WRS;
  localparam int NV  = 12;

  // vector: {we, addr[15:0], data[3:0]}; for reads data is the expected word
  localparam logic [20:0] VEC [NV] = '{
    {1'b1, 16'h0000, 4'h5}, {1'b1, 16'hFFFF, 4'hA}, {1'b0, 16'h0000, 4'h5},
    {1'b1, 16'h1234, 4'hF}, {1'b0, 16'hFFFF, 4'hA}, {1'b0, 16'h1234, 4'hF},
    {1'b1, 16'hA5C3, 4'h3}, {1'b1, 16'h0000, 4'hC}, {1'b0, 16'hA5C3, 4'h3},
    {1'b0, 16'h0000, 4'hC}, {1'b1, 16'h7F01, 4'h9}, {1'b0, 16'h7F01, 4'h9}
  };

  logic        clk, rst_n;
  logic        host_req, host_we, host_rdy;
  logic [15:0] host_addr, mem_addr;
  logic [3:0]  host_wdata, host_rdata, mem_dq_o, mem_dq_i;
  logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;

  int checks, errors;
  bit done;

  sram_seq_ctrl #(
    .RD_WAIT_CYC (RDW), .WR_PULSE_CYC (WRP), .WR_SETUP_CYC (WRS), .TURN_CYC (TRN)
  ) uut (
    .clk (clk), .rst_n (rst_n),
    .host_req (host_req), .host_we (host_we), .host_addr (host_addr),
    .host_wdata (host_wdata), .host_rdy (host_rdy), .host_rdata (host_rdata),
    .mem_ce_n (mem_ce_n), .mem_we_n (mem_we_n), .mem_oe_n (mem_oe_n),
    .mem_addr (mem_addr), .mem_dq_o (mem_dq_o), .mem_dq_oe (mem_dq_oe),
    .mem_dq_i (mem_dq_i)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // ---- small memory model: 64 slots tagged with the full address ----
  logic [3:0]  mv [64];
  logic [15:0] mt [64];
  logic        mk [64];
  int          acc, wl_cnt, gap;
  bit          pend, prev_oe;
  logic [15:0] pa;
  logic [3:0]  pd;

  initial begin
    for (int i = 0; i < 64; i++) begin mv[i] = '0; mt[i] = '0; mk[i] = 1'b0; end
    acc = 0; wl_cnt = 0; pend = 0; gap = TRN; prev_oe = 0;
  end

  always_comb begin
    mem_dq_i = 4'h0;
    if (!mem_ce_n && !mem_oe_n && mem_we_n && acc >= RDW &&
        mk[mem_addr[5:0]] && mt[mem_addr[5:0]] == mem_addr)
      mem_dq_i = mv[mem_addr[5:0]];
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_ce_n && !mem_oe_n && mem_we_n) acc++; else acc = 0;
      if (mem_dq_oe && !mem_oe_n) chk(1'b0, "R6 contention", 1, 0);
      if (mem_dq_oe && !prev_oe) chk(gap >= TRN, "R6 turnaround gap", gap, TRN);
      if (!mem_oe_n) gap = 0; else if (!mem_dq_oe) gap++;
      prev_oe = mem_dq_oe;
      if (!mem_we_n) begin
        if (!pend) begin pa = mem_addr; pd = mem_dq_o; end
        chk(!mem_ce_n && mem_oe_n, "R5 strobe inside select", {mem_ce_n, mem_oe_n}, 1);
        chk(mem_dq_oe && mem_dq_o == pd && mem_addr == pa, "R3 R4 data/addr held", mem_dq_o, pd);
        pend = 1; wl_cnt++;
      end else if (pend) begin
        chk(wl_cnt == WLO, "R3 strobe width", wl_cnt, WLO);
        mv[pa[5:0]] = pd; mt[pa[5:0]] = pa; mk[pa[5:0]] = 1'b1;
        pend = 0; wl_cnt = 0;
      end
    end
  end

  task automatic idle_chk(input string rq);
    chk(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !host_rdy, rq,
        {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, host_rdy}, 5'b11100);
  endtask

  // call at a negedge in idle; returns at a negedge in idle
  task automatic op(input logic we, input logic [15:0] a, input logic [3:0] d);
    int n;
    idle_chk("R1 idle between ops");
    host_req = 1'b1; host_we = we; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_req = 1'b0; n = 0;
    if (!we) chk(!mem_ce_n && !mem_oe_n && mem_we_n && mem_addr == a,
                 "R2 read strobes", mem_addr, a);
    while (!host_rdy && n < 50) begin @(negedge clk); n++; end
    chk(n == (we ? WLO : RDW), we ? "R3 write latency" : "R2 read latency", n, we ? WLO : RDW);
    if (!we) chk(host_rdata == d, "R2 read data", host_rdata, d);
    else chk(mem_dq_oe && mem_we_n && mem_dq_o == d, "R9 zero-hold drive", mem_dq_o, d);
    @(negedge clk);
    chk(!host_rdy, "R7 ready one cycle", host_rdy, 0);
    if (!we) repeat (TRN - 1) @(negedge clk);
  endtask

  initial begin
    checks = 0; errors = 0; done = 0;
    host_req = 0; host_we = 0; host_addr = '0; host_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    idle_chk("R1 reset state");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    idle_chk("R1 after reset release");

    for (int i = 0; i < NV; i++) op(VEC[i][20], VEC[i][19:4], VEC[i][3:0]);

    // R8: write request raised while a read is running is dropped
    host_req = 1'b1; host_we = 1'b0; host_addr = 16'h1234; host_wdata = 4'h0;
    @(negedge clk);
    host_we = 1'b1; host_wdata = 4'h6;
    @(negedge clk);
    host_req = 1'b0;
    @(negedge clk);
    chk(host_rdy && host_rdata == 4'hF, "R8 first op completes", host_rdata, 4'hF);
    begin
      int extra;
      extra = 0;
      repeat (12) begin
        @(negedge clk);
        if (host_rdy || !mem_we_n) extra++;
      end
      chk(extra == 0, "R8 no second cycle", extra, 0);
    end
    op(1'b0, 16'h1234, 4'hF);

    // R6: write right after a read at minimum spacing, then read it back
    op(1'b0, 16'hFFFF, 4'hA);
    op(1'b1, 16'hFFFF, 4'h2);
    op(1'b0, 16'hFFFF, 4'h2);

    // R1: asynchronous reset in mid-operation returns strobes high
    host_req = 1'b1; host_we = 1'b1; host_addr = 16'h0101; host_wdata = 4'h7;
    @(negedge clk);
    host_req = 1'b0;
    #2 rst_n = 1'b0;
    #1 idle_chk("R1 async reset mid-write");
    pend = 0; wl_cnt = 0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    idle_chk("R1 idle after reset");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule